// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer sitting on a simple 32-bit register bus. Software programs a tick divisor and a timeout, turns counting on, and must then keep issuing restart commands. A base tick strobe (typically one pulse per microsecond) feeds a prescaler. Each time the prescaler wraps, a down-counter loses one. If the counter runs out while counting is on, the block raises a one-cycle reset request toward the system reset controller. It also sets a sticky flag that records that the watchdog caused the reset.

Two synchronous active-low resets reach the block. The system reset clears the timer state but leaves the reset-cause flag alone, so software can read it after the watchdog reset. The power-on reset clears everything. Safe reconfiguration follows a fixed order: disable, rewrite the divisor and the timeout, restart, enable.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0, the load register reads 0x0000FFFF, the reset-status register reads 0 and `rst_req` is low.
- R2: The control register at offset 0x20 keeps the divisor in bits [31:16] and the count enable in bit 7; it reads back these fields, and all other bits read as 0.
- R3: The load register at offset 0x24 keeps bits [15:0], and its upper bits read as 0. Writing it does not change a count already running; the new value is used at the next restart.
- R4: A write to offset 0x00 with bit 9 set reloads the counter from the load register and clears the prescaler phase. A write to 0x00 with bit 9 clear has no effect on the countdown.
- R5: While enabled, the counter decrements once every D base ticks, with a divisor of 0 treated as D=1. After a restart with load N, expiry occurs on base tick D*N, and a load of 0 expires on base tick D.
- R6: While counting is disabled, base ticks are ignored and the count is frozen.
- R7: On expiry `rst_req` is high for exactly one cycle, in the cycle after the clock edge that sampled the final base tick. The counter then holds at zero and issues no further request until a restart.
- R8: Bit 1 of the reset-status register at offset 0x38 is set on expiry. It survives the system reset and is cleared by power-on reset or by writing 1 to bit 1; writing 0 leaves it set.
- R9: Turning counting on (0 to 1 on bit 7) clears the prescaler phase, so a full D base ticks are needed for the first decrement.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears everything |
| rst_n | input | 1 | System reset, synchronous, active low; keeps the reset-cause flag |
| tick_in | input | 1 | Base tick strobe, one clock cycle wide |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The assertions assume that `tick_in` is a clean one-cycle strobe. They also assume the divisor is not rewritten while counting is on, since a shrinking divisor can leave the prescaler phase above its new limit. The stimulus always changes the divisor with counting disabled and follows it with a restart and an enable, as the safe sequence requires. Bus writes are single-cycle, driven away from the clock edge, and never coincide with a reset.

// File: rtl/wdog_pkg.sv
// Package wdog_pkg
// Purpose : shared register offsets and bit positions for the watchdog.
// Assumes : byte-addressed 32-bit registers; decoders compare full offsets.
package wdog_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;

    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_LOAD   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_RCAUSE = 8'h38;

    localparam int BIT_RESTART = 9;
    localparam int BIT_EN      = 7;
    localparam int BIT_CAUSE   = 1;
    localparam int DIV_LSB     = 16;
endpackage

// File: rtl/wdog_regs.sv
// Module wdog_regs
// Purpose : register file of the watchdog (control, load, restart command,
//           reset-cause flag) plus the combinational read mux.
// Assumes : single-cycle writes; PRE_W <= 16 and CNT_W <= 16 so that each
//           field fits its half of the word.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              fire,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              en,
    output logic [PRE_W-1:0]  div,
    output logic [CNT_W-1:0]  load,
    output logic              restart,
    output logic              en_rise,
    output logic              cause
);
    localparam logic [CNT_W-1:0] LOAD_RST = '1;

    logic wr_stat, wr_ctrl, wr_load, wr_rc;
    logic sys_rst;

    assign sys_rst = !rst_n || !por_n;

    // Decode which register a write targets.
    always_comb begin
        wr_stat = bus_wr && (bus_addr == OFS_STAT);
        wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
        wr_load = bus_wr && (bus_addr == OFS_LOAD);
        wr_rc   = bus_wr && (bus_addr == OFS_RCAUSE);
    end

    assign restart = wr_stat && bus_wdata[BIT_RESTART];
    assign en_rise = wr_ctrl && bus_wdata[BIT_EN] && !en;

    // Control register: enable bit and divisor field.
    always_ff @(posedge clk) begin
        if (sys_rst) begin
            en  <= 1'b0;
            div <= '0;
        end else if (wr_ctrl) begin
            en  <= bus_wdata[BIT_EN];
            div <= bus_wdata[DIV_LSB +: PRE_W];
        end
    end

    // Load register: timeout in prescaled ticks.
    always_ff @(posedge clk) begin
        if (sys_rst)      load <= LOAD_RST;
        else if (wr_load) load <= bus_wdata[CNT_W-1:0];
    end

    // Reset-cause flag: only power-on clears it, set wins over write-1-clear.
    always_ff @(posedge clk) begin
        if (!por_n)                             cause <= 1'b0;
        else if (fire)                          cause <= 1'b1;
        else if (wr_rc && bus_wdata[BIT_CAUSE]) cause <= 1'b0;
    end

    // Read mux: unmapped bits and offsets read zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[DIV_LSB +: PRE_W] = div;
                bus_rdata[BIT_EN]           = en;
            end
            OFS_LOAD:   bus_rdata[CNT_W-1:0] = load;
            OFS_RCAUSE: bus_rdata[BIT_CAUSE] = cause;
            default:    bus_rdata = '0;
        endcase
    end

    // R8: the flag is not lost without power-on reset or a write of 1.
    a_r8_cause_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (cause && !(wr_rc && bus_wdata[BIT_CAUSE])) |=> cause);

    // R2: a control write is visible on the following cycle.
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (sys_rst)
        wr_ctrl |=> (en == $past(bus_wdata[BIT_EN])));
endmodule

// File: rtl/wdog_presc.sv
// Module wdog_presc
// Purpose : divides the base tick strobe by the programmed divisor and
//           emits one prescaled tick event per wrap.
// Assumes : divisor changes only while disabled; divisor 0 means divide by 1.
module wdog_presc #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic             en,
    input  logic             tick_in,
    input  logic [PRE_W-1:0] div,
    input  logic             clr,
    output logic             tick_ev
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] lim;

    // Last phase value before the wrap.
    assign lim = (div == '0) ? '0 : div - 1'b1;

    assign tick_ev = en && tick_in && !clr && (pcnt >= lim);

    // Phase counter: cleared by restart or enable edge, advanced by base ticks.
    always_ff @(posedge clk) begin
        if (!srst_n)              pcnt <= '0;
        else if (clr)             pcnt <= '0;
        else if (en && tick_in)   pcnt <= (pcnt >= lim) ? '0 : pcnt + 1'b1;
    end

    // R5: the phase stays within the divisor while the divisor is stable.
    a_r5_phase_bound: assert property (@(posedge clk) disable iff (!srst_n)
        ($stable(div) && $past(pcnt) <= $past(lim)) |-> (pcnt <= lim));

    // R9: a clear request leaves the phase at zero.
    a_r9_phase_clear: assert property (@(posedge clk) disable iff (!srst_n)
        clr |=> (pcnt == '0));
endmodule

// File: rtl/wdog_count.sv
// Module wdog_count
// Purpose : timeout down-counter with expiry detection and hold-at-zero.
// Assumes : tick_ev arrives only while counting is enabled.
module wdog_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] load,
    input  logic             tick_ev,
    output logic             fire,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic expd;

    // Expire on the tick that takes the count to zero (or finds it there).
    assign fire = tick_ev && !expd && !restart && (count <= ONE);

    // Counter and expired marker.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            count <= '1;
            expd  <= 1'b0;
        end else if (restart) begin
            count <= load;
            expd  <= 1'b0;
        end else if (fire) begin
            count <= '0;
            expd  <= 1'b1;
        end else if (tick_ev && !expd) begin
            count <= count - 1'b1;
        end
    end

    // R7: once expired the counter sits at zero.
    a_r7_hold_zero: assert property (@(posedge clk) disable iff (!srst_n)
        expd |-> (count == '0));

    // R4: a restart loads the programmed timeout.
    a_r4_reload: assert property (@(posedge clk) disable iff (!srst_n)
        restart |=> (count == $past(load)));

    // R5: without restart the count never rises.
    a_r5_monotonic: assert property (@(posedge clk) disable iff (!srst_n)
        !restart |=> (count <= $past(count)));
endmodule

// File: rtl/wdog_timer.sv
// Module wdog_timer
// Purpose : top of the watchdog; joins register file, prescaler and counter
//           and registers the one-cycle reset request.
// Assumes : tick_in is a one-cycle strobe; the system reset controller turns
//           rst_req into rst_n, and power-on drives por_n.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);
    logic             srst_n;
    logic             en, restart, en_rise, cause, fire, tick_ev;
    logic [PRE_W-1:0] div;
    logic [CNT_W-1:0] load, count;

    assign srst_n = rst_n && por_n;

    wdog_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .fire      (fire),
        .bus_rdata (bus_rdata),
        .en        (en),
        .div       (div),
        .load      (load),
        .restart   (restart),
        .en_rise   (en_rise),
        .cause     (cause)
    );

    wdog_presc #(.PRE_W(PRE_W)) u_presc (
        .clk     (clk),
        .srst_n  (srst_n),
        .en      (en),
        .tick_in (tick_in),
        .div     (div),
        .clr     (restart || en_rise),
        .tick_ev (tick_ev)
    );

    wdog_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .srst_n  (srst_n),
        .restart (restart),
        .load    (load),
        .tick_ev (tick_ev),
        .fire    (fire),
        .count   (count)
    );

    // Reset request: one registered cycle per expiry.
    always_ff @(posedge clk) begin
        if (!srst_n) rst_req <= 1'b0;
        else         rst_req <= fire;
    end

    // R7: the request lasts a single cycle.
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!srst_n)
        rst_req |=> !rst_req);

    // R8: every request is accompanied by the cause flag.
    a_r8_cause_on_req: assert property (@(posedge clk) disable iff (!srst_n)
        rst_req |-> cause);

    // R6: with counting off and no restart the count is frozen.
    a_r6_frozen: assert property (@(posedge clk) disable iff (!srst_n)
        (!en && !restart) |=> $stable(count));
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wdog_timer dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_in(tick_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    typedef struct packed {
        logic [15:0] div;
        logic [15:0] load;
        int          exp_ticks;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{16'd1, 16'd5, 5},
        '{16'd3, 16'd4, 12},
        '{16'd0, 16'd3, 3},
        '{16'd2, 16'd0, 2},
        '{16'd5, 16'd2, 10}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // One base tick; returns rst_req seen in the cycle after its edge.
    task automatic tick(output logic seen);
        @(negedge clk);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        seen = rst_req;
    endtask

    // Ticks until a request; returns tick count, also checks pulse width.
    task automatic ticks_to_fire(input string req, output int n);
        logic s;
        n = 0;
        s = 1'b0;
        while (!s && n < 200) begin
            tick(s);
            n++;
        end
        @(negedge clk);
        chk({req, " pulse width"}, {31'b0, rst_req}, 32'd0);
    endtask

    task automatic quiet_ticks(input string req, input int k);
        logic s;
        int hits = 0;
        for (int i = 0; i < k; i++) begin
            tick(s);
            if (s) hits++;
        end
        chk(req, hits, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(8'h20, d); chk("R1 ctrl", d, 32'h0);
        rd(8'h24, d); chk("R1 load", d, 32'h0000FFFF);
        rd(8'h38, d); chk("R1 cause", d, 32'h0);
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);

        // R2 control readback, other bits read zero
        wr(8'h20, 32'h03E8_FF7F); rd(8'h20, d); chk("R2 ctrl readback", d, 32'h03E8_0000);
        wr(8'h20, 32'h03E8_FFFF); rd(8'h20, d); chk("R2 ctrl enable", d, 32'h03E8_0080);
        wr(8'h20, 32'h0);
        // R3 upper load bits dropped
        wr(8'h24, 32'h1234_5678); rd(8'h24, d); chk("R3 load width", d, 32'h0000_5678);

        // R5 table of divisor/load against expiry tick
        for (int v = 0; v < 5; v++) begin
            wr(8'h20, {VECS[v].div, 16'h0000});
            wr(8'h24, {16'h0, VECS[v].load});
            wr(8'h00, 32'h200);
            wr(8'h20, {VECS[v].div, 16'h0080});
            ticks_to_fire("R5 vector", n);
            chk("R5 expiry tick", n, VECS[v].exp_ticks);
        end

        // R6 disabled: ticks ignored, count frozen
        wr(8'h20, 32'h0001_0000); wr(8'h24, 32'd2); wr(8'h00, 32'h200);
        quiet_ticks("R6 no expiry while disabled", 10);
        wr(8'h20, 32'h0001_0080);
        ticks_to_fire("R6", n); chk("R6 count frozen", n, 2);

        // R4 restarts keep it alive
        wr(8'h24, 32'd3); wr(8'h00, 32'h200);
        for (int r = 0; r < 3; r++) begin
            quiet_ticks("R4 keep alive", 2);
            wr(8'h00, 32'h200);
        end
        ticks_to_fire("R4", n); chk("R4 after restarts", n, 3);

        // R4 status write without bit 9 has no effect
        wr(8'h00, 32'h200);
        quiet_ticks("R4 one tick", 1);
        wr(8'h00, 32'h0000_01FF);
        ticks_to_fire("R4", n); chk("R4 no-restart write", n, 2);

        // R3 load write alone does not change running count; R7 hold
        wr(8'h24, 32'd3); wr(8'h00, 32'h200); wr(8'h24, 32'd10);
        ticks_to_fire("R3", n); chk("R3 load deferred", n, 3);
        quiet_ticks("R7 hold at zero", 12);

        // R8 cause flag
        rd(8'h38, d); chk("R8 cause set", d, 32'h2);
        wr(8'h38, 32'h0); rd(8'h38, d); chk("R8 write 0 keeps", d, 32'h2);
        @(negedge clk); rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1;
        rd(8'h38, d); chk("R8 survives system reset", d, 32'h2);
        rd(8'h20, d); chk("R1 ctrl after system reset", d, 32'h0);
        wr(8'h38, 32'h2); rd(8'h38, d); chk("R8 write 1 clears", d, 32'h0);

        // R9 enable edge clears prescaler phase
        wr(8'h20, 32'h0004_0000); wr(8'h24, 32'd1); wr(8'h00, 32'h200);
        wr(8'h20, 32'h0004_0080);
        quiet_ticks("R9 partial", 2);
        wr(8'h20, 32'h0004_0000); wr(8'h20, 32'h0004_0080);
        ticks_to_fire("R9", n); chk("R9 full period after enable", n, 4);

        // R4 restart clears prescaler phase
        wr(8'h24, 32'd2); wr(8'h00, 32'h200);
        quiet_ticks("R4 partial phase", 3);
        wr(8'h00, 32'h200);
        ticks_to_fire("R4", n); chk("R4 phase cleared by restart", n, 8);

        // R8 power-on reset clears the flag
        rd(8'h38, d); chk("R8 set again", d, 32'h2);
        @(negedge clk); por_n = 1'b0; @(negedge clk); @(negedge clk); por_n = 1'b1;
        rd(8'h38, d); chk("R8 cleared by power-on", d, 32'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule